// File: doc/BRIEF.md
# Infrared Link Interrupt Aggregator

This block collects the event pulses of an infrared link controller and turns them into a single interrupt request. Events come from the transmitter (frame sent), the receiver (frame received, timeout, framing fault, abort, CRC fault) and the frame buffer (transfer area overflow). They are routed to one of two register banks, chosen by the active transfer mode: an asynchronous bank for the slow mode, and a synchronous bank shared by the medium and fast modes. Each bank has a status register, a mask register and a write-one-to-clear register.

Two status bits change meaning with the mode. Bit 9 is a receive timeout in the asynchronous bank and an abort detection in the synchronous bank. Bit 8 is a framing error in the asynchronous bank and a CRC error in the synchronous bank. A mode register holds the 2-bit transfer-mode field and three top-level mask bits: one per bank and one for a FIFO receive request. Software works with it in a fixed order. It masks and clears both banks, opens the bank of the active mode, and on each interrupt reads that bank's status and writes the same value back to the clear register.

Top module: `irda_irq_ctrl`

## Requirements
- R1: The mode register keeps the transfer-mode field in bits 15:14, encoded 00 = slow, 11 = medium, 10 = fast. 01 is reserved. The register reads back bits 15, 14, 8, 4 and 0 as written, and reads every other bit as zero.
- R2: In slow mode (00), the events are set into the asynchronous bank at these positions: frame-receive-end at bit 15, overflow at bit 11, receive timeout at bit 9, framing error at bit 8, frame-transmit-end at bit 7. A status bit stays set until it is cleared. The synchronous bank is not touched.
- R3: In medium (11) and fast (10) modes, the events go to the synchronous bank at the same common positions, with abort at bit 9 and CRC error at bit 8. Timeout and framing events set nothing in either mode family's opposite bank, and abort and CRC events are ignored in slow mode.
- R4: Writing a value to a bank's clear register clears every status bit written as 1 and leaves the bits written as 0. Writing back the value read from status clears all pending events at once.
- R5: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: Each bank's mask register blocks the interrupt for every status bit whose mask bit is 1.
- R7: Mode register bit 0 blocks the whole asynchronous bank and bit 4 blocks the whole synchronous bank when set.
- R8: The FIFO receive request input raises the interrupt only while mode register bit 8 is 0.
- R9: Status and mask registers hold only bits 15, 11, 9, 8 and 7. Other bits ignore writes and read as zero. Clear registers read as zero, and status registers ignore writes.
- R10: After reset the mode register reads 0x0111, both mask registers read 0x8B80, both status registers read 0 and the interrupt is low.
- R11: In the reserved mode 01, no event sets a bit in either bank.

Register addresses: 0 mode, 1 async status, 2 async mask, 3 async clear, 4 sync status, 5 sync mask, 6 sync clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data for reg_addr (combinational) |
| ev_rx_end | input | 1 | Frame receive end pulse |
| ev_overflow | input | 1 | Transfer area overflow pulse |
| ev_tx_end | input | 1 | Frame transmit end pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse (slow mode) |
| ev_framing_err | input | 1 | Framing error pulse (slow mode) |
| ev_abort | input | 1 | Abort detection pulse (medium/fast) |
| ev_crc_err | input | 1 | CRC error pulse (medium/fast) |
| fifo_rx_req | input | 1 | FIFO receive request level |
| irq | output | 1 | Interrupt request |

## Verification
Most state faults in this block reach the pins in one of two ways: through the status read-back one cycle after the offending edge, or through irq in the same cycle the register changes. A routing fault shows up as the wrong bank's status gaining a bit. A clear that is lost or too wide shows up as a stale bit or a missing bit in the next status read. A broken gate in the mask path shows up as irq rising when every mask bit is set, or staying low once the path is opened.

// File: rtl/irda_irq_pkg.sv
package irda_irq_pkg;
  localparam int REG_W = 16;
  localparam int NBANK = 2;

  // status bit positions, shared by both banks
  localparam int B_RX_END = 15;
  localparam int B_OVF    = 11;
  localparam int B_ALT9   = 9;
  localparam int B_ALT8   = 8;
  localparam int B_TX_END = 7;

  // mode register fields
  localparam int MODE_LSB   = 14;
  localparam int TOPM_FIFO  = 8;
  localparam int TOPM_SYNC  = 4;
  localparam int TOPM_ASYNC = 0;

  localparam logic [REG_W-1:0] EVT_BITS  = 16'h8B80;
  localparam logic [REG_W-1:0] MODE_BITS = 16'hC111;
  localparam logic [REG_W-1:0] MODE_RST  = 16'h0111;

  // register map
  localparam int RA_MODE = 0;
  localparam int RA_STAT [NBANK] = '{1, 4};
  localparam int RA_MASK [NBANK] = '{2, 5};
  localparam int RA_CLR  [NBANK] = '{3, 6};

  typedef enum logic [1:0] {
    LINK_SLOW = 2'b00,
    LINK_RSVD = 2'b01,
    LINK_FAST = 2'b10,
    LINK_MED  = 2'b11
  } link_mode_e;

  function automatic logic link_is_async(input link_mode_e m);
    return m == LINK_SLOW;
  endfunction

  function automatic logic link_is_sync(input link_mode_e m);
    return (m == LINK_MED) || (m == LINK_FAST);
  endfunction

  function automatic logic [REG_W-1:0] evt_fold(input logic [REG_W-1:0] v);
    return v & EVT_BITS;
  endfunction

  function automatic logic [REG_W-1:0] evt_vec(input logic rx_end, input logic ovf,
                                               input logic alt9, input logic alt8,
                                               input logic tx_end);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_RX_END] = rx_end;
    v[B_OVF]    = ovf;
    v[B_ALT9]   = alt9;
    v[B_ALT8]   = alt8;
    v[B_TX_END] = tx_end;
    return v;
  endfunction
endpackage

// File: rtl/irda_ev_router.sv
module irda_ev_router
  import irda_irq_pkg::*;
(
  input  link_mode_e                   link_mode,
  input  logic                         ev_rx_end,
  input  logic                         ev_overflow,
  input  logic                         ev_tx_end,
  input  logic                         ev_rx_timeout,
  input  logic                         ev_framing_err,
  input  logic                         ev_abort,
  input  logic                         ev_crc_err,
  output logic [NBANK-1:0][REG_W-1:0]  set_vec
);
  logic [REG_W-1:0] async_vec;
  logic [REG_W-1:0] sync_vec;

  always_comb begin
    async_vec = evt_vec(ev_rx_end, ev_overflow, ev_rx_timeout, ev_framing_err, ev_tx_end);
    sync_vec  = evt_vec(ev_rx_end, ev_overflow, ev_abort, ev_crc_err, ev_tx_end);
    set_vec[0] = link_is_async(link_mode) ? async_vec : '0;
    set_vec[1] = link_is_sync(link_mode)  ? sync_vec  : '0;
  end
endmodule

// File: rtl/irda_mode_reg.sv
module irda_mode_reg
  import irda_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mode_q,
  output link_mode_e       link_mode,
  output logic             top_mask_async,
  output logic             top_mask_sync,
  output logic             top_mask_fifo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_RST;
    else if (wr_en) mode_q <= wr_data & MODE_BITS;
  end

  assign link_mode      = link_mode_e'(mode_q[MODE_LSB +: 2]);
  assign top_mask_async = mode_q[TOPM_ASYNC];
  assign top_mask_sync  = mode_q[TOPM_SYNC];
  assign top_mask_fifo  = mode_q[TOPM_FIFO];
endmodule

// File: rtl/irda_status_bank.sv
module irda_status_bank
  import irda_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [REG_W-1:0] mask_wdata,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] mask_q,
  output logic             pend_any
);
  logic [REG_W-1:0] status_d;

  // set has priority over a clear of the same bit
  always_comb status_d = evt_fold((status_q & ~clr_vec) | set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= EVT_BITS;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= evt_fold(mask_wdata);
    end
  end

  assign pend_any = |(status_q & ~mask_q);
endmodule

// File: rtl/irda_irq_ctrl.sv
module irda_irq_ctrl
  import irda_irq_pkg::*;
#(
  parameter int ADDR_W = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wr_data,
  output logic [15:0]       reg_rd_data,
  input  logic              ev_rx_end,
  input  logic              ev_overflow,
  input  logic              ev_tx_end,
  input  logic              ev_rx_timeout,
  input  logic              ev_framing_err,
  input  logic              ev_abort,
  input  logic              ev_crc_err,
  input  logic              fifo_rx_req,
  output logic              irq
);
  logic [REG_W-1:0]            mode_q;
  link_mode_e                  link_mode;
  logic                        top_mask_async;
  logic                        top_mask_sync;
  logic                        top_mask_fifo;
  logic [NBANK-1:0][REG_W-1:0] set_vec;
  logic [NBANK-1:0][REG_W-1:0] clr_vec;
  logic [NBANK-1:0][REG_W-1:0] status_q;
  logic [NBANK-1:0][REG_W-1:0] mask_q;
  logic [NBANK-1:0]            mask_we;
  logic [NBANK-1:0]            pend_any;
  logic [NBANK-1:0]            bank_open;
  logic                        mode_we;

  assign mode_we = reg_wr_en && (reg_addr == ADDR_W'(RA_MODE));

  irda_mode_reg u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (mode_we),
    .wr_data        (reg_wr_data),
    .mode_q         (mode_q),
    .link_mode      (link_mode),
    .top_mask_async (top_mask_async),
    .top_mask_sync  (top_mask_sync),
    .top_mask_fifo  (top_mask_fifo)
  );

  irda_ev_router u_route (
    .link_mode      (link_mode),
    .ev_rx_end      (ev_rx_end),
    .ev_overflow    (ev_overflow),
    .ev_tx_end      (ev_tx_end),
    .ev_rx_timeout  (ev_rx_timeout),
    .ev_framing_err (ev_framing_err),
    .ev_abort       (ev_abort),
    .ev_crc_err     (ev_crc_err),
    .set_vec        (set_vec)
  );

  assign bank_open[0] = !top_mask_async;
  assign bank_open[1] = !top_mask_sync;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign mask_we[b] = reg_wr_en && (reg_addr == ADDR_W'(RA_MASK[b]));
    assign clr_vec[b] = (reg_wr_en && (reg_addr == ADDR_W'(RA_CLR[b]))) ? reg_wr_data : '0;

    irda_status_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec[b]),
      .clr_vec    (clr_vec[b]),
      .mask_we    (mask_we[b]),
      .mask_wdata (reg_wr_data),
      .status_q   (status_q[b]),
      .mask_q     (mask_q[b]),
      .pend_any   (pend_any[b])
    );
  end

  assign irq = |(pend_any & bank_open) | (fifo_rx_req & ~top_mask_fifo);

  always_comb begin
    reg_rd_data = '0;
    if (reg_addr == ADDR_W'(RA_MODE)) reg_rd_data = mode_q;
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == ADDR_W'(RA_STAT[b])) reg_rd_data = status_q[b];
      if (reg_addr == ADDR_W'(RA_MASK[b])) reg_rd_data = mask_q[b];
    end
  end
endmodule

// File: rtl/irda_irq_chk.sv
module irda_irq_chk
  import irda_irq_pkg::*;
#(
  parameter int ADDR_W = 3
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic [REG_W-1:0]            mode_q,
  input logic [NBANK-1:0][REG_W-1:0] set_vec,
  input logic [NBANK-1:0][REG_W-1:0] clr_vec,
  input logic [NBANK-1:0][REG_W-1:0] status_q,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [15:0]                 reg_rd_data,
  input logic                        irq
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    // R2: a pending bit stays until a clear hits it
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> ((($past(status_q[b]) & ~$past(clr_vec[b])) & ~status_q[b]) == '0));
    // R4: a clear without a same-cycle set leaves the bit low
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> ((status_q[b] & $past(clr_vec[b]) & ~$past(set_vec[b])) == '0));
    // R5: an event always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> ((status_q[b] & $past(set_vec[b])) == $past(set_vec[b])));
  end

  // R3: slow mode never feeds the synchronous bank
  a_r3_async_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[15:14] == 2'b00) |-> (set_vec[1] == '0));
  // R3: medium/fast never feed the asynchronous bank
  a_r3_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15] |-> (set_vec[0] == '0));
  // R11: reserved mode routes nothing
  a_r11_no_route: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[15:14] == 2'b01) |-> (set_vec == '0));
  // R7, R8: all top-level masks set keeps irq low
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && mode_q[4] && mode_q[8]) |-> !irq);
  // R9: non-mode registers read only defined event bits
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(RA_MODE)) |-> ((reg_rd_data & ~EVT_BITS) == '0));
endmodule

bind irda_irq_ctrl irda_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .status_q    (status_q),
  .reg_addr    (reg_addr),
  .reg_rd_data (reg_rd_data),
  .irq         (irq)
);

// File: tb/tb_irda_irq_ctrl.sv
module tb_irda_irq_ctrl;
  localparam int AW = 3;
  localparam logic [2:0] A_MODE = 3'd0, A_SST = 3'd1, A_SMK = 3'd2, A_SCL = 3'd3,
                         A_FST = 3'd4, A_FMK = 3'd5, A_FCL = 3'd6;
  // event selector bits
  localparam logic [6:0] E_RXEND = 7'h01, E_OVF = 7'h02, E_TXEND = 7'h04, E_TMO = 7'h08,
                         E_FRM = 7'h10, E_ABT = 7'h20, E_CRC = 7'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [6:0] ev = '0;
  logic fifo_req = 1'b0;
  logic irq;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irda_irq_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
    .reg_wr_data(wdata), .reg_rd_data(rdata),
    .ev_rx_end(ev[0]), .ev_overflow(ev[1]), .ev_tx_end(ev[2]), .ev_rx_timeout(ev[3]),
    .ev_framing_err(ev[4]), .ev_abort(ev[5]), .ev_crc_err(ev[6]),
    .fifo_rx_req(fifo_req), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input logic [6:0] sel);
    @(negedge clk);
    ev = sel;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    rd_check("R10 mode", A_MODE, 16'h0111);
    rd_check("R10 async mask", A_SMK, 16'h8B80);
    rd_check("R10 sync mask", A_FMK, 16'h8B80);
    rd_check("R10 async status", A_SST, 16'h0000);
    rd_check("R10 sync status", A_FST, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_mode_field;
    wr(A_MODE, 16'hFFFF);
    rd_check("R1 R9 mode readback", A_MODE, 16'hC111);
    wr(A_MODE, 16'h8010);
    rd_check("R1 fast encoding", A_MODE, 16'h8010);
    wr(A_MODE, 16'h0000);
  endtask

  task automatic t_slow_route;
    pulse(E_RXEND | E_TMO);
    pulse(E_FRM);
    rd_check("R2 async status", A_SST, 16'h8300);
    rd_check("R2 sync untouched", A_FST, 16'h0000);
    pulse(E_ABT | E_CRC);
    rd_check("R3 abort/crc ignored in slow", A_SST, 16'h8300);
    rd_check("R3 sync still clear", A_FST, 16'h0000);
    check("R6 masked irq low", {15'd0, irq}, 16'h0000);
    wr(A_SMK, 16'h7FFF);
    check("R6 bit15 open irq high", {15'd0, irq}, 16'h0001);
    wr(A_SCL, 16'h8000);
    rd_check("R4 partial clear", A_SST, 16'h0300);
    check("R6 remaining bits masked", {15'd0, irq}, 16'h0000);
    wr(A_SCL, 16'h0300);
    rd_check("R4 write-back clears all", A_SST, 16'h0000);
    pulse(E_OVF | E_TXEND);
    rd_check("R2 overflow and tx end", A_SST, 16'h0880);
    wr(A_SCL, 16'h0880);
    wr(A_SMK, 16'h8B80);
  endtask

  task automatic t_sync_route;
    wr(A_MODE, 16'hC000);
    pulse(E_ABT | E_CRC | E_TXEND | E_OVF);
    pulse(E_TMO | E_FRM);
    rd_check("R3 medium routes to sync", A_FST, 16'h0B80);
    rd_check("R3 async untouched", A_SST, 16'h0000);
    wr(A_FCL, 16'h0B80);
    wr(A_MODE, 16'h8000);
    pulse(E_RXEND);
    rd_check("R3 fast routes to sync", A_FST, 16'h8000);
  endtask

  task automatic t_top_mask;
    wr(A_FMK, 16'h0000);
    check("R6 sync open irq", {15'd0, irq}, 16'h0001);
    wr(A_MODE, 16'h8010);
    check("R7 sync bank top mask", {15'd0, irq}, 16'h0000);
    rd_check("R7 status kept under top mask", A_FST, 16'h8000);
    wr(A_MODE, 16'h8001);
    check("R7 async bit leaves sync open", {15'd0, irq}, 16'h0001);
    wr(A_FCL, 16'h8000);
    check("R4 irq drops after clear", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_set_wins;
    wr(A_MODE, 16'h8000);
    @(negedge clk);
    ev = E_TXEND; wr_en = 1'b1; addr = A_FCL; wdata = 16'hFFFF;
    @(negedge clk);
    ev = '0; wr_en = 1'b0;
    rd_check("R5 set beats clear", A_FST, 16'h0080);
    wr(A_FCL, 16'h0080);
    rd_check("R4 cleared afterwards", A_FST, 16'h0000);
  endtask

  task automatic t_reserved_mode;
    wr(A_MODE, 16'h4000);
    pulse(7'h7F);
    rd_check("R11 async empty", A_SST, 16'h0000);
    rd_check("R11 sync empty", A_FST, 16'h0000);
  endtask

  task automatic t_fifo;
    wr(A_MODE, 16'h0111);
    fifo_req = 1'b1;
    #1;
    check("R8 fifo masked", {15'd0, irq}, 16'h0000);
    wr(A_MODE, 16'h0011);
    check("R8 fifo open", {15'd0, irq}, 16'h0001);
    fifo_req = 1'b0;
    #1;
    check("R8 fifo released", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_reserved_bits;
    wr(A_SMK, 16'hFFFF);
    rd_check("R9 mask keeps defined bits", A_SMK, 16'h8B80);
    wr(A_FMK, 16'h7477);
    rd_check("R9 mask undefined bits zero", A_FMK, 16'h0000);
    rd_check("R9 clear reads zero", A_SCL, 16'h0000);
    wr(A_SST, 16'hFFFF);
    rd_check("R9 status ignores write", A_SST, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_field();
    t_slow_route();
    t_sync_route();
    t_top_mask();
    t_set_wins();
    t_reserved_mode();
    t_fifo();
    t_reserved_bits();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule